// File: doc/BRIEF.md
# Bus Error Status Capture Unit

This unit sits beside the controller of a PCI-style parallel bus and keeps the error record for it. Each cycle the controller reports what it saw on the current transaction: a parity-error indication from the bus, a data parity mismatch it found itself, an address parity mismatch, a system-error indication, a missing device-select response, or a target abort. It also reports the transaction's address, command, direction, and whether this controller started it. The unit sorts these observations into six error types and records each type as a sticky bit in a status word. A repeat of a type that is already recorded raises a separate multiple-error flag.

The first qualifying error freezes a snapshot of its transaction: the address, command, direction, initiator, and every error type raised in that cycle. Software can exclude any type from triggering the snapshot through a disable word. Software clears status bits by writing ones to them. Once every error-type bit is clear, the snapshot is dropped and capture is armed again. A single level interrupt stays high while any status bit is set.

Top module: `bus_err_capture`

## Requirements
- R1: After reset, the status word, the capture-disable word, the captured address and the captured attribute word all read zero, and both `cap_valid_o` and `irq_o` are low.
- R2: Status bit 21 (address parity) is set when an address parity mismatch is reported on a transaction started by another device, and never when this controller started the transaction. Status bit 22 (system error) is set whenever the system-error indication is reported.
- R3: Status bit 23 (master parity) is set when this controller started the transaction and either the bus parity-error indication arrives on a write or a data parity mismatch is detected on a read. A parity-error indication on its own read does not set it.
- R4: Status bit 24 (target parity) is set when another device started the transaction and either the bus parity-error indication arrives on a read or a data parity mismatch is detected on a write. A parity-error indication on a write does not set it.
- R5: Status bit 25 (no response) is set for a missing device-select response, and status bit 26 (target abort) is set for a target abort, in both cases only on transactions this controller started.
- R6: Status bits are sticky and are cleared by writing 1 to them at byte offset 0x00. Bits 1 to 20 and 27 to 31 always read zero and ignore writes. A bit that is set by an event and cleared by software in the same cycle ends up set.
- R7: Status bit 0 (multiple error) is set when an error type occurs while its status bit was already 1 at the start of that cycle, including when the same cycle clears it. Raising a different type does not set it.
- R8: The capture-disable word at byte offset 0x04 resets to zero, holds bits 21 to 26 (the same positions as the status types), and reads zero elsewhere. A 1 stops that type from triggering a capture but still lets it set its status bit.
- R9: Only the first qualifying error is captured. Later errors update status but leave the snapshot unchanged. When several types arrive in one cycle, all of them set status, capture happens if any one of them is enabled, and the captured type field lists every type raised in that cycle.
- R10: When writes leave all of status bits 21 to 26 at zero, `cap_valid_o` drops and the captured fields read zero on the following cycle. The next qualifying error is then captured. Status bit 0 alone does not hold the capture.
- R11: `irq_o` is high exactly while any of status bits 0 and 21 to 26 is set.
- R12: Offset 0x08 reads the captured address. Offset 0x0C reads the attribute word: command in bits 7:0, write in bit 8, initiated-by-this-controller in bit 9, captured types in bits 21 to 26, and valid in bit 31. Addresses that are not word-aligned or are past 0x0C read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_master_i | input | 1 | Current transaction was started by this controller |
| txn_write_i | input | 1 | Current transaction is a write |
| txn_addr_i | input | ADDR_W | Current transaction address |
| txn_cmd_i | input | CMD_W | Current transaction bus command |
| obs_perr_i | input | 1 | Bus parity-error indication seen this cycle |
| obs_dpe_i | input | 1 | Data parity mismatch detected by this controller |
| obs_ape_i | input | 1 | Address parity mismatch detected |
| obs_serr_i | input | 1 | System-error indication seen |
| obs_nodevsel_i | input | 1 | Transaction got no device-select response |
| obs_tabort_i | input | 1 | Transaction ended in a target abort |
| reg_addr_i | input | RA_W | Register byte address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from reg_addr_i) |
| status_o | output | 32 | Status word |
| cap_valid_o | output | 1 | A snapshot is held |
| cap_addr_o | output | ADDR_W | Captured address |
| cap_cmd_o | output | CMD_W | Captured command |
| cap_write_o | output | 1 | Captured direction (1 = write) |
| cap_master_o | output | 1 | Captured transaction was started by this controller |
| cap_types_o | output | 6 | Error types raised in the capturing cycle, status bit 21 first |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is an event of a type arriving in the very cycle software clears that same type. This tests both the set-over-clear rule and the pre-clear view used for the multiple-error bit. The stimulus drives one register write and one error strobe together in the same low clock phase. A second hard case is the re-arm boundary. The bench clears the error bits one at a time and in between reads the snapshot, so it can tell a capture still held apart from one dropped early. It also builds a state where only the multiple-error bit remains, to show that this bit alone neither holds the capture nor drops the interrupt.

// File: rtl/bec_pkg.sv
package bec_pkg;

  localparam int N_ERR     = 6;
  localparam int ERR_LSB   = 21;
  localparam int MULTI_BIT = 0;
  localparam int REG_W     = 32;

  // error type index within the six-bit type field
  localparam int E_APE   = 0;
  localparam int E_SERR  = 1;
  localparam int E_MPERR = 2;
  localparam int E_TPERR = 3;
  localparam int E_NORSP = 4;
  localparam int E_TABT  = 5;

  typedef enum logic [1:0] {
    RS_STATUS = 2'd0,
    RS_MASK   = 2'd1,
    RS_CADDR  = 2'd2,
    RS_CATTR  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic perr;
    logic dpe;
    logic ape;
    logic serr;
    logic nodevsel;
    logic tabort;
  } bus_obs_t;

  // Sort raw bus observations into error types.
  function automatic logic [N_ERR-1:0] classify(input logic master,
                                                 input logic write,
                                                 input bus_obs_t o);
    logic [N_ERR-1:0] t;
    t          = '0;
    t[E_APE]   = o.ape & ~master;
    t[E_SERR]  = o.serr;
    t[E_MPERR] = master & ((o.perr & write) | (o.dpe & ~write));
    t[E_TPERR] = ~master & ((o.perr & ~write) | (o.dpe & write));
    t[E_NORSP] = master & o.nodevsel;
    t[E_TABT]  = master & o.tabort;
    return t;
  endfunction

  // One sticky bit: a set beats a clear in the same cycle.
  function automatic logic sticky_next(input logic q, input logic clr, input logic set);
    return set | (q & ~clr);
  endfunction

  function automatic logic want_capture(input logic held,
                                        input logic [N_ERR-1:0] raised,
                                        input logic [N_ERR-1:0] disabled);
    return ~held & (|(raised & ~disabled));
  endfunction

  function automatic logic [REG_W-1:0] status_word(input logic multi,
                                                   input logic [N_ERR-1:0] errs);
    logic [REG_W-1:0] w;
    w                      = '0;
    w[MULTI_BIT]           = multi;
    w[ERR_LSB +: N_ERR]    = errs;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] type_field_mask();
    logic [REG_W-1:0] w;
    w                   = '0;
    w[ERR_LSB +: N_ERR] = '1;
    return w;
  endfunction

endpackage

// File: rtl/bec_classify.sv
module bec_classify
  import bec_pkg::*;
(
  input  logic             master_i,
  input  logic             write_i,
  input  bus_obs_t         obs_i,
  output logic [N_ERR-1:0] raised_o
);

  always_comb raised_o = classify(master_i, write_i, obs_i);

endmodule

// File: rtl/bec_status.sv
module bec_status
  import bec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ERR-1:0] raised_i,
  input  logic [N_ERR-1:0] clr_err_i,
  input  logic             clr_multi_i,
  output logic [N_ERR-1:0] err_o,
  output logic             multi_o,
  output logic             repeat_hit_o,
  output logic             all_clear_o
);

  logic [N_ERR-1:0] err_q;
  logic [N_ERR-1:0] err_d;
  logic             multi_q;

  // repeat is judged against the bits as they stood at the start of the cycle
  assign repeat_hit_o = |(raised_i & err_q);

  for (genvar g = 0; g < N_ERR; g++) begin : g_bit
    assign err_d[g] = sticky_next(err_q[g], clr_err_i[g], raised_i[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q[g] <= 1'b0;
      else        err_q[g] <= err_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) multi_q <= 1'b0;
    else        multi_q <= sticky_next(multi_q, clr_multi_i, repeat_hit_o);
  end

  assign all_clear_o = (err_d == '0);
  assign err_o       = err_q;
  assign multi_o     = multi_q;

endmodule

// File: rtl/bec_mask.sv
module bec_mask
  import bec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] word_o
);

  localparam logic [REG_W-1:0] KEEP = type_field_mask();

  logic [REG_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (wr_i) word_q <= wdata_i & KEEP;
  end

  assign word_o = word_q;

endmodule

// File: rtl/bec_capture.sv
module bec_capture
  import bec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ERR-1:0]  raised_i,
  input  logic [N_ERR-1:0]  disabled_i,
  input  logic              rearm_i,
  input  logic              master_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic              fire_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              write_o,
  output logic              master_o,
  output logic [N_ERR-1:0]  types_o
);

  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              write_q;
  logic              master_q;
  logic [N_ERR-1:0]  types_q;

  assign fire_o = want_capture(valid_q, raised_i, disabled_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      addr_q   <= '0;
      cmd_q    <= '0;
      write_q  <= 1'b0;
      master_q <= 1'b0;
      types_q  <= '0;
    end else if (fire_o) begin
      valid_q  <= 1'b1;
      addr_q   <= addr_i;
      cmd_q    <= cmd_i;
      write_q  <= write_i;
      master_q <= master_i;
      types_q  <= raised_i;
    end else if (rearm_i) begin
      valid_q  <= 1'b0;
      addr_q   <= '0;
      cmd_q    <= '0;
      write_q  <= 1'b0;
      master_q <= 1'b0;
      types_q  <= '0;
    end
  end

  assign valid_o  = valid_q;
  assign addr_o   = addr_q;
  assign cmd_o    = cmd_q;
  assign write_o  = write_q;
  assign master_o = master_q;
  assign types_o  = types_q;

endmodule

// File: rtl/bus_err_capture.sv
// ADDR_W must not exceed 32 and CMD_W must not exceed 8 (register read layout).
module bus_err_capture
  import bec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4,
  parameter int RA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_master_i,
  input  logic              txn_write_i,
  input  logic [ADDR_W-1:0] txn_addr_i,
  input  logic [CMD_W-1:0]  txn_cmd_i,
  input  logic              obs_perr_i,
  input  logic              obs_dpe_i,
  input  logic              obs_ape_i,
  input  logic              obs_serr_i,
  input  logic              obs_nodevsel_i,
  input  logic              obs_tabort_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [REG_W-1:0]  status_o,
  output logic              cap_valid_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [CMD_W-1:0]  cap_cmd_o,
  output logic              cap_write_o,
  output logic              cap_master_o,
  output logic [N_ERR-1:0]  cap_types_o,
  output logic              irq_o
);

  localparam int ATTR_WR_BIT  = 8;
  localparam int ATTR_MST_BIT = 9;
  localparam int ATTR_VLD_BIT = 31;

  // named internal events, observed by the bound checker
  bus_obs_t         obs;
  logic [N_ERR-1:0] new_err;
  logic [N_ERR-1:0] mask_field;
  logic [N_ERR-1:0] err_bits;
  logic             multi_bit;
  logic             repeat_hit;
  logic             rearm;
  logic             cap_fire;
  logic             reg_hit;
  reg_sel_e         reg_sel;
  logic             wr_status;
  logic             wr_mask;
  logic [REG_W-1:0] mask_word;
  logic [REG_W-1:0] attr_word;
  logic [REG_W-1:0] caddr_word;

  assign obs = '{perr:     obs_perr_i,
                 dpe:      obs_dpe_i,
                 ape:      obs_ape_i,
                 serr:     obs_serr_i,
                 nodevsel: obs_nodevsel_i,
                 tabort:   obs_tabort_i};

  // register decode: word aligned, offsets 0x00..0x0C only
  assign reg_hit   = (reg_addr_i[1:0] == 2'b00) && (reg_addr_i[RA_W-1:4] == '0);
  assign reg_sel   = reg_sel_e'(reg_addr_i[3:2]);
  assign wr_status = reg_we_i && reg_hit && (reg_sel == RS_STATUS);
  assign wr_mask   = reg_we_i && reg_hit && (reg_sel == RS_MASK);

  bec_classify u_classify (
    .master_i (txn_master_i),
    .write_i  (txn_write_i),
    .obs_i    (obs),
    .raised_o (new_err)
  );

  bec_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .raised_i     (new_err),
    .clr_err_i    (wr_status ? reg_wdata_i[ERR_LSB +: N_ERR] : '0),
    .clr_multi_i  (wr_status & reg_wdata_i[MULTI_BIT]),
    .err_o        (err_bits),
    .multi_o      (multi_bit),
    .repeat_hit_o (repeat_hit),
    .all_clear_o  (rearm)
  );

  bec_mask u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_mask),
    .wdata_i (reg_wdata_i),
    .word_o  (mask_word)
  );

  assign mask_field = mask_word[ERR_LSB +: N_ERR];

  bec_capture #(
    .ADDR_W (ADDR_W),
    .CMD_W  (CMD_W)
  ) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .raised_i   (new_err),
    .disabled_i (mask_field),
    .rearm_i    (rearm),
    .master_i   (txn_master_i),
    .write_i    (txn_write_i),
    .addr_i     (txn_addr_i),
    .cmd_i      (txn_cmd_i),
    .fire_o     (cap_fire),
    .valid_o    (cap_valid_o),
    .addr_o     (cap_addr_o),
    .cmd_o      (cap_cmd_o),
    .write_o    (cap_write_o),
    .master_o   (cap_master_o),
    .types_o    (cap_types_o)
  );

  assign status_o = status_word(multi_bit, err_bits);
  assign irq_o    = multi_bit | (|err_bits);

  always_comb begin
    caddr_word             = '0;
    caddr_word[ADDR_W-1:0] = cap_addr_o;
  end

  always_comb begin
    attr_word                      = '0;
    attr_word[CMD_W-1:0]           = cap_cmd_o;
    attr_word[ATTR_WR_BIT]         = cap_write_o;
    attr_word[ATTR_MST_BIT]        = cap_master_o;
    attr_word[ERR_LSB +: N_ERR]    = cap_types_o;
    attr_word[ATTR_VLD_BIT]        = cap_valid_o;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_hit) begin
      unique case (reg_sel)
        RS_STATUS: reg_rdata_o = status_o;
        RS_MASK:   reg_rdata_o = mask_word;
        RS_CADDR:  reg_rdata_o = caddr_word;
        RS_CATTR:  reg_rdata_o = attr_word;
        default:   reg_rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/bec_checker.sv
module bec_checker
  import bec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_master_i,
  input logic [REG_W-1:0]  status_o,
  input logic              cap_valid_o,
  input logic [ADDR_W-1:0] cap_addr_o,
  input logic              irq_o,
  input logic [N_ERR-1:0]  new_err,
  input logic [N_ERR-1:0]  mask_field,
  input logic              rearm
);

  localparam logic [REG_W-1:0] LIVE = type_field_mask() | REG_W'(1);

  // R6: reserved status bits never read one
  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & ~LIVE) == '0);

  // R2: a raised type shows in status on the next cycle
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|new_err) |=> ((status_o[ERR_LSB +: N_ERR] & $past(new_err)) == $past(new_err)));

  // R2: address parity bit only rises after a transaction started elsewhere
  assert_ape_other_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[ERR_LSB + E_APE]) |-> $past(!txn_master_i));

  // R5: abort and no-response bits only rise after own transactions
  assert_own_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status_o[ERR_LSB + E_TABT]) || $rose(status_o[ERR_LSB + E_NORSP]))
      |-> $past(txn_master_i));

  // R7: a repeated type sets the multiple-error flag
  assert_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(new_err & status_o[ERR_LSB +: N_ERR])) |=> status_o[MULTI_BIT]);

  // R8: only disabled types raised -> no new capture
  assert_masked_nocap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_valid_o && ((new_err & ~mask_field) == '0)) |=> !cap_valid_o);

  // R9: a held snapshot is never overwritten
  assert_keep_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid_o && !rearm) |=> (cap_valid_o && $stable(cap_addr_o)));

  // R10: clearing all type bits drops the snapshot
  assert_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !cap_valid_o);

  // R11: interrupt only rises with a live status bit
  assert_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ((status_o & LIVE) != '0));

endmodule

bind bus_err_capture bec_checker #(
  .ADDR_W (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .txn_master_i (txn_master_i),
  .status_o     (status_o),
  .cap_valid_o  (cap_valid_o),
  .cap_addr_o   (cap_addr_o),
  .irq_o        (irq_o),
  .new_err      (new_err),
  .mask_field   (mask_field),
  .rearm        (rearm)
);

// File: tb/tb_bus_err_capture.sv
module tb_bus_err_capture;

  localparam int AW = 32;
  localparam int CW = 4;
  localparam int RW = 8;

  // observation codes, order {tabort, nodevsel, serr, ape, dpe, perr}
  localparam logic [5:0] O_PERR = 6'b000001;
  localparam logic [5:0] O_DPE  = 6'b000010;
  localparam logic [5:0] O_APE  = 6'b000100;
  localparam logic [5:0] O_SERR = 6'b001000;
  localparam logic [5:0] O_NDS  = 6'b010000;
  localparam logic [5:0] O_TAB  = 6'b100000;

  // status bit values: multi bit 0, types at 21..26
  localparam logic [31:0] S_MUL  = 32'h0000_0001;
  localparam logic [31:0] S_APE  = 32'h0020_0000;
  localparam logic [31:0] S_SERR = 32'h0040_0000;
  localparam logic [31:0] S_MPE  = 32'h0080_0000;
  localparam logic [31:0] S_TPE  = 32'h0100_0000;
  localparam logic [31:0] S_NRS  = 32'h0200_0000;
  localparam logic [31:0] S_TAB  = 32'h0400_0000;
  localparam logic [31:0] A_VLD  = 32'h8000_0000;
  localparam logic [31:0] A_MST  = 32'h0000_0200;
  localparam logic [31:0] A_WR   = 32'h0000_0100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          txn_master, txn_write;
  logic [AW-1:0] txn_addr;
  logic [CW-1:0] txn_cmd;
  logic          o_perr, o_dpe, o_ape, o_serr, o_nds, o_tab;
  logic [RW-1:0] reg_addr;
  logic          reg_we;
  logic [31:0]   reg_wdata, reg_rdata, status;
  logic          cap_valid, cap_write, cap_master, irq;
  logic [AW-1:0] cap_addr;
  logic [CW-1:0] cap_cmd;
  logic [5:0]    cap_types;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;  // 125 MHz

  bus_err_capture #(.ADDR_W(AW), .CMD_W(CW), .RA_W(RW)) dut (
    .clk(clk), .rst_n(rst_n),
    .txn_master_i(txn_master), .txn_write_i(txn_write),
    .txn_addr_i(txn_addr), .txn_cmd_i(txn_cmd),
    .obs_perr_i(o_perr), .obs_dpe_i(o_dpe), .obs_ape_i(o_ape),
    .obs_serr_i(o_serr), .obs_nodevsel_i(o_nds), .obs_tabort_i(o_tab),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .status_o(status),
    .cap_valid_o(cap_valid), .cap_addr_o(cap_addr), .cap_cmd_o(cap_cmd),
    .cap_write_o(cap_write), .cap_master_o(cap_master), .cap_types_o(cap_types),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_obs(input logic [5:0] o);
    {o_tab, o_nds, o_serr, o_ape, o_dpe, o_perr} = o;
  endtask

  task automatic idle();
    set_obs(6'b0);
    txn_master = 0; txn_write = 0; txn_addr = '0; txn_cmd = '0;
    reg_we = 0; reg_addr = '0; reg_wdata = '0;
  endtask

  // one-cycle event, results visible when the task returns
  task automatic ev(input logic m, input logic w, input logic [31:0] a,
                    input logic [3:0] c, input logic [5:0] o);
    @(negedge clk);
    txn_master = m; txn_write = w; txn_addr = a; txn_cmd = c; set_obs(o);
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_we = 0; reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic clear_all();
    wr(8'h00, 32'hFFFF_FFFF);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset();
    rd_chk("R1 status", 8'h00, 32'h0);
    rd_chk("R1 mask",   8'h04, 32'h0);
    rd_chk("R1 caddr",  8'h08, 32'h0);
    rd_chk("R1 cattr",  8'h0C, 32'h0);
    chk("R1 valid", {31'b0, cap_valid}, 32'h0);
    chk("R1 irq",   {31'b0, irq}, 32'h0);
  endtask

  task automatic one_case(input string tag, input logic m, input logic w,
                          input logic [5:0] o, input logic [31:0] exp);
    ev(m, w, 32'h0000_1000, 4'h6, o);
    rd_chk(tag, 8'h00, exp);
    clear_all();
  endtask

  task automatic t_classify();
    one_case("R2 ape other",      0, 0, O_APE,  S_APE);
    one_case("R2 ape own",        1, 0, O_APE,  32'h0);
    one_case("R2 serr",           1, 1, O_SERR, S_SERR);
    one_case("R3 perr own write", 1, 1, O_PERR, S_MPE);
    one_case("R3 dpe own read",   1, 0, O_DPE,  S_MPE);
    one_case("R3 perr own read",  1, 0, O_PERR, 32'h0);
    one_case("R4 perr tgt read",  0, 0, O_PERR, S_TPE);
    one_case("R4 dpe tgt write",  0, 1, O_DPE,  S_TPE);
    one_case("R4 perr tgt write", 0, 1, O_PERR, 32'h0);
    one_case("R5 nodevsel own",   1, 0, O_NDS,  S_NRS);
    one_case("R5 nodevsel other", 0, 0, O_NDS,  32'h0);
    one_case("R5 tabort own",     1, 1, O_TAB,  S_TAB);
    one_case("R5 tabort other",   0, 1, O_TAB,  32'h0);
  endtask

  task automatic t_w1c();
    ev(0, 0, 32'h10, 4'h1, O_APE);
    ev(1, 0, 32'h20, 4'h1, O_SERR);
    rd_chk("R6 both set", 8'h00, S_APE | S_SERR);
    chk("R11 irq high", {31'b0, irq}, 32'h1);
    wr(8'h00, S_APE);
    rd_chk("R6 w1c one", 8'h00, S_SERR);
    wr(8'h00, 32'hF81F_FFFE);
    rd_chk("R6 reserved write", 8'h00, S_SERR);
    clear_all();
    rd_chk("R6 all cleared", 8'h00, 32'h0);
    chk("R11 irq low", {31'b0, irq}, 32'h0);
    // set and clear the same bit in one cycle
    ev(0, 0, 32'h30, 4'h2, O_APE);
    @(negedge clk);
    txn_master = 0; txn_write = 0; set_obs(O_APE);
    reg_addr = 8'h00; reg_wdata = S_APE; reg_we = 1;
    @(negedge clk);
    idle();
    rd_chk("R6 set beats clear, R7 pre-clear repeat", 8'h00, S_APE | S_MUL);
    clear_all();
  endtask

  task automatic t_multi();
    ev(0, 0, 32'h40, 4'h1, O_APE);
    ev(1, 0, 32'h44, 4'h1, O_SERR);
    rd_chk("R7 different type", 8'h00, S_APE | S_SERR);
    ev(0, 0, 32'h48, 4'h1, O_APE);
    rd_chk("R7 repeat", 8'h00, S_APE | S_SERR | S_MUL);
    wr(8'h00, S_MUL);
    rd_chk("R7 clear multi", 8'h00, S_APE | S_SERR);
    clear_all();
  endtask

  task automatic t_mask_first();
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk("R8 mask readback", 8'h04, 32'h07E0_0000);
    wr(8'h04, S_SERR);
    ev(1, 0, 32'h50, 4'h1, O_SERR);
    rd_chk("R8 masked status", 8'h00, S_SERR);
    chk("R8 masked no capture", {31'b0, cap_valid}, 32'h0);
    rd_chk("R8 attr empty", 8'h0C, 32'h0);
    ev(1, 1, 32'h1234_5678, 4'h7, O_TAB);
    rd_chk("R12 caddr", 8'h08, 32'h1234_5678);
    rd_chk("R12 cattr", 8'h0C, A_VLD | S_TAB | A_MST | A_WR | 32'h7);
    ev(0, 0, 32'hDEAD_0000, 4'hC, O_PERR);
    rd_chk("R9 later status", 8'h00, S_SERR | S_TAB | S_TPE);
    rd_chk("R9 first kept", 8'h08, 32'h1234_5678);
    chk("R9 cmd kept", {28'b0, cap_cmd}, 32'h7);
    clear_all();
    // several types in one cycle, one of them disabled
    wr(8'h04, S_NRS);
    ev(1, 1, 32'hA5A5_0000, 4'h3, O_PERR | O_NDS | O_TAB);
    rd_chk("R9 same-cycle status", 8'h00, S_MPE | S_NRS | S_TAB);
    rd_chk("R9 same-cycle types", 8'h0C, A_VLD | S_MPE | S_NRS | S_TAB | A_MST | A_WR | 32'h3);
    clear_all();
    // all raised types disabled
    wr(8'h04, S_MPE | S_NRS);
    ev(1, 1, 32'hB000_0000, 4'h3, O_PERR | O_NDS);
    rd_chk("R9 all-disabled status", 8'h00, S_MPE | S_NRS);
    chk("R9 all-disabled no capture", {31'b0, cap_valid}, 32'h0);
    clear_all();
    wr(8'h04, 32'h0);
  endtask

  task automatic t_rearm();
    ev(0, 0, 32'h100, 4'h1, O_APE);
    ev(1, 0, 32'h200, 4'h1, O_SERR);
    wr(8'h00, S_APE);
    chk("R10 partial clear keeps", {31'b0, cap_valid}, 32'h1);
    rd_chk("R10 partial clear addr", 8'h08, 32'h100);
    wr(8'h00, S_SERR);
    chk("R10 full clear drops", {31'b0, cap_valid}, 32'h0);
    rd_chk("R10 addr zero", 8'h08, 32'h0);
    ev(1, 0, 32'h300, 4'h2, O_SERR);
    rd_chk("R10 recapture", 8'h08, 32'h300);
    clear_all();
    ev(0, 0, 32'h400, 4'h1, O_APE);
    ev(0, 0, 32'h404, 4'h1, O_APE);
    wr(8'h00, S_APE);
    rd_chk("R10 only multi left", 8'h00, S_MUL);
    chk("R10 multi does not hold", {31'b0, cap_valid}, 32'h0);
    chk("R11 irq from multi", {31'b0, irq}, 32'h1);
    wr(8'h00, S_MUL);
    chk("R11 irq cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_decode();
    wr(8'h06, 32'hFFFF_FFFF);
    rd_chk("R12 misaligned write ignored", 8'h04, 32'h0);
    ev(0, 0, 32'h500, 4'h1, O_APE);
    rd_chk("R12 misaligned read", 8'h01, 32'h0);
    rd_chk("R12 out of range read", 8'h10, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk("R12 out of range write ignored", 8'h00, S_APE);
    clear_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_classify();
    t_w1c();
    t_multi();
    t_mask_first();
    t_rearm();
    t_decode();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule